// File: doc/BRIEF.md
# Selective Load-Miss Replay Tracker

This block follows micro-ops that were sent toward execution on the assumption that the load feeding them would hit in the first-level data cache. Each tracked micro-op carries a vector of the outstanding load tags it relies on. That vector holds the loads it names directly, plus every tag held by the tracked producers it names as sources, so a dependence reaches through any number of hops. A hit report for a tag removes that tag from every vector. A micro-op whose vector becomes empty is no longer speculative and leaves the tracker.

A miss report for a tag cancels exactly the tracked micro-ops whose vector contains it. Micro-ops outside that chain are not touched. Cancelled micro-ops stay in the tracker until fill data for every missed tag they wait on has returned. They are then reissued on a replay port, one per cycle, oldest dispatch first, beginning the cycle after the fill. A new micro-op that inherits a tag that has already missed is cancelled as soon as it is accepted. When every entry is occupied, the dispatch port stalls.

Top module: `rt_replay_tracker`

## Requirements
- R1: After reset, no entry is tracked: `cancel_vec` is zero, `rpl_valid` is low and `disp_ready` is high.
- R2: A dispatch accepted with a non-empty dependence vector takes the lowest-numbered free entry. `disp_tracked` is high and `disp_entry` gives that index. A dispatch with an empty vector is not tracked (`disp_tracked` low).
- R3: The dependence vector of a dispatched micro-op is the OR of `disp_ld_mask` (bit k set means load tag k) and the current vectors of the valid entries named by `disp_src0_ent`/`disp_src1_ent`, each used only when its valid flag is set.
- R4: A hit report (`rpt_valid`, `rpt_hit`=1) clears the bit of `rpt_tag` in every entry. An entry that then has no bits and is not waiting for replay is freed at that clock edge.
- R5: A miss report (`rpt_valid`, `rpt_hit`=0) makes `cancel_vec` show, in the next cycle and for one cycle, every entry whose vector holds that tag and that was not already cancelled. Bit i of `cancel_vec` is entry i.
- R6: A cancelled entry is not reissued while any tag in its vector has missed without a fill.
- R7: Replay issue picks, among entries that are ready to reissue, the one dispatched earliest. At most one is reissued per cycle. The first reissue is in the cycle after the `fill_valid` for the last missed tag the entry waits on, and `rpl_uop_id` is the id given at dispatch.
- R8: When all entries are occupied, `disp_ready` is low, and a dispatch offered in that state allocates nothing (`disp_tracked` low).
- R9: A micro-op dispatched with a vector that holds a tag that has already missed and not yet been filled is cancelled at once: its bit in `cancel_vec` is set in the next cycle.
- R10: A fill for a tag clears that tag from every vector. A reissued entry whose vector still holds other tags stays allocated until those tags are also cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_uop_id | input | UOP_W | Identifier of the dispatched micro-op |
| disp_ld_mask | input | N_LD | Load tags the micro-op reads directly |
| disp_src0_vld | input | 1 | First source names a tracked producer |
| disp_src0_ent | input | log2(N_ENT) | Entry index of the first producer |
| disp_src1_vld | input | 1 | Second source names a tracked producer |
| disp_src1_ent | input | log2(N_ENT) | Entry index of the second producer |
| disp_ready | output | 1 | A free entry exists, so a dispatch is accepted |
| disp_tracked | output | 1 | This dispatch was allocated an entry |
| disp_entry | output | log2(N_ENT) | Entry allocated to this dispatch |
| rpt_valid | input | 1 | Hit/miss report for a load tag |
| rpt_tag | input | log2(N_LD) | Load tag of the report |
| rpt_hit | input | 1 | 1 for a hit, 0 for a miss |
| fill_valid | input | 1 | Fill data for a missed load has returned |
| fill_tag | input | log2(N_LD) | Load tag of the fill |
| cancel_vec | output | N_ENT | One-cycle cancel pulse per entry |
| rpl_valid | output | 1 | A micro-op is being reissued |
| rpl_entry | output | log2(N_ENT) | Entry being reissued |
| rpl_uop_id | output | UOP_W | Identifier of the reissued micro-op |

## Verification
A corrupted dependence vector shows up at the next miss on the affected tag: the cancel pulse one cycle later has a bit set that should be clear, or a bit clear that should be set. A wrong free/valid bit shows up when the next dispatch is allocated, as the wrong `disp_entry`, or as a `disp_ready` level that differs from the count of live entries. Faults in age order or in the replay gate appear in the cycle after a fill, as a replay in the wrong order or at the wrong time. The reference model is compared against every output on every cycle, so each of these faults is flagged in the cycle it reaches a port.

// File: rtl/rt_pkg.sv
package rt_pkg;
    localparam int RT_ENTRIES = 16;
    localparam int RT_LOADS   = 4;
    localparam int RT_UOP_W   = 8;
endpackage

// File: rtl/rt_first_free.sv
// Lowest-index free slot finder.
module rt_first_free #(
    parameter int N  = 16,
    parameter int EW = 4
) (
    input  logic [N-1:0]  busy,
    output logic          found,
    output logic [EW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                found = 1'b1;
                idx   = EW'(i);
            end
        end
    end
endmodule

// File: rtl/rt_age_pick.sv
// Oldest-first selection using an age matrix: older[g][j] = entry j is older than g.
module rt_age_pick #(
    parameter int N  = 16,
    parameter int EW = 4
) (
    input  logic [N-1:0]         elig,
    input  logic [N-1:0][N-1:0]  older,
    output logic [N-1:0]         pick,
    output logic                 any,
    output logic [EW-1:0]        idx
);
    for (genvar g = 0; g < N; g++) begin : g_row
        assign pick[g] = elig[g] & ~(|(elig & older[g]));
    end

    assign any = |pick;

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (pick[i]) idx = EW'(i);
        end
    end
endmodule

// File: rtl/rt_dep_merge.sv
// Builds the dependence vector of a new micro-op from direct tags and producers.
module rt_dep_merge #(
    parameter int N  = 16,
    parameter int L  = 4,
    parameter int EW = 4
) (
    input  logic [N-1:0]         vld,
    input  logic [N-1:0][L-1:0]  mask,
    input  logic [L-1:0]         ld_mask,
    input  logic                 s0_v,
    input  logic [EW-1:0]        s0_e,
    input  logic                 s1_v,
    input  logic [EW-1:0]        s1_e,
    output logic [L-1:0]         dep
);
    always_comb begin
        dep = ld_mask;
        if (s0_v && vld[s0_e]) dep = dep | mask[s0_e];
        if (s1_v && vld[s1_e]) dep = dep | mask[s1_e];
    end
endmodule

// File: rtl/rt_replay_tracker.sv
module rt_replay_tracker
    import rt_pkg::*;
#(
    parameter int N_ENT = RT_ENTRIES,
    parameter int N_LD  = RT_LOADS,
    parameter int UOP_W = RT_UOP_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      disp_valid,
    input  logic [UOP_W-1:0]          disp_uop_id,
    input  logic [N_LD-1:0]           disp_ld_mask,
    input  logic                      disp_src0_vld,
    input  logic [$clog2(N_ENT)-1:0]  disp_src0_ent,
    input  logic                      disp_src1_vld,
    input  logic [$clog2(N_ENT)-1:0]  disp_src1_ent,
    output logic                      disp_ready,
    output logic                      disp_tracked,
    output logic [$clog2(N_ENT)-1:0]  disp_entry,
    input  logic                      rpt_valid,
    input  logic [$clog2(N_LD)-1:0]   rpt_tag,
    input  logic                      rpt_hit,
    input  logic                      fill_valid,
    input  logic [$clog2(N_LD)-1:0]   fill_tag,
    output logic [N_ENT-1:0]          cancel_vec,
    output logic                      rpl_valid,
    output logic [$clog2(N_ENT)-1:0]  rpl_entry,
    output logic [UOP_W-1:0]          rpl_uop_id
);
    localparam int ENT_W = $clog2(N_ENT);

    typedef struct packed {
        logic [N_ENT-1:0]                vld;
        logic [N_ENT-1:0][N_LD-1:0]      mask;
        logic [N_ENT-1:0]                rpl;
        logic [N_ENT-1:0][UOP_W-1:0]     uop;
        logic [N_ENT-1:0][N_ENT-1:0]     older;
        logic [N_ENT-1:0]                cancel;
        logic [N_LD-1:0]                 missed;
    } trk_state_t;

    trk_state_t state_q, state_d;

    logic              free_found;
    logic [ENT_W-1:0]  free_idx;
    logic [N_LD-1:0]   dep_mask;
    logic [N_ENT-1:0]  elig;
    logic [N_ENT-1:0]  pick_vec;
    logic              pick_any;
    logic [ENT_W-1:0]  pick_idx;
    logic              alloc;
    logic [N_ENT-1:0]  ent_vld;

    rt_first_free #(.N(N_ENT), .EW(ENT_W)) u_free (
        .busy  (state_q.vld),
        .found (free_found),
        .idx   (free_idx)
    );

    rt_dep_merge #(.N(N_ENT), .L(N_LD), .EW(ENT_W)) u_merge (
        .vld     (state_q.vld),
        .mask    (state_q.mask),
        .ld_mask (disp_ld_mask),
        .s0_v    (disp_src0_vld),
        .s0_e    (disp_src0_ent),
        .s1_v    (disp_src1_vld),
        .s1_e    (disp_src1_ent),
        .dep     (dep_mask)
    );

    // An entry may reissue once none of its tags is in the missed set.
    for (genvar g = 0; g < N_ENT; g++) begin : g_elig
        assign elig[g] = state_q.vld[g] & state_q.rpl[g]
                       & ~(|(state_q.mask[g] & state_q.missed));
    end

    rt_age_pick #(.N(N_ENT), .EW(ENT_W)) u_pick (
        .elig  (elig),
        .older (state_q.older),
        .pick  (pick_vec),
        .any   (pick_any),
        .idx   (pick_idx)
    );

    assign ent_vld      = state_q.vld;
    assign disp_ready   = free_found;
    assign alloc        = disp_valid & free_found & (|dep_mask);
    assign disp_tracked = alloc;
    assign disp_entry   = free_idx;
    assign cancel_vec   = state_q.cancel;
    assign rpl_valid    = pick_any;
    assign rpl_entry    = pick_idx;
    assign rpl_uop_id   = state_q.uop[pick_idx];

    always_comb begin
        state_d        = state_q;
        state_d.cancel = '0;

        // reissue of the selected entry
        if (pick_any) state_d.rpl[pick_idx] = 1'b0;

        // allocation
        if (alloc) begin
            state_d.vld[free_idx]   = 1'b1;
            state_d.mask[free_idx]  = dep_mask;
            state_d.uop[free_idx]   = disp_uop_id;
            state_d.older[free_idx] = state_q.vld;
            for (int i = 0; i < N_ENT; i++) begin
                state_d.older[i][free_idx] = 1'b0;
            end
            if (|(dep_mask & state_q.missed)) begin
                state_d.rpl[free_idx]    = 1'b1;
                state_d.cancel[free_idx] = 1'b1;
            end else begin
                state_d.rpl[free_idx]    = 1'b0;
            end
        end

        // hit / miss report
        if (rpt_valid) begin
            if (!rpt_hit) state_d.missed[rpt_tag] = 1'b1;
            for (int i = 0; i < N_ENT; i++) begin
                if (state_d.vld[i] && state_d.mask[i][rpt_tag]) begin
                    if (rpt_hit) begin
                        state_d.mask[i][rpt_tag] = 1'b0;
                    end else begin
                        if (!state_d.rpl[i]) state_d.cancel[i] = 1'b1;
                        state_d.rpl[i] = 1'b1;
                    end
                end
            end
        end

        // fill return
        if (fill_valid) begin
            state_d.missed[fill_tag] = 1'b0;
            for (int i = 0; i < N_ENT; i++) begin
                state_d.mask[i][fill_tag] = 1'b0;
            end
        end

        // retirement of entries that are no longer speculative
        for (int i = 0; i < N_ENT; i++) begin
            if (state_d.vld[i] && (state_d.mask[i] == '0) && !state_d.rpl[i]) begin
                state_d.vld[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/rt_replay_tracker_chk.sv
module rt_replay_tracker_chk #(
    parameter int N_ENT = 16,
    parameter int N_LD  = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [N_ENT-1:0]          ent_vld,
    input logic [N_ENT-1:0]          pick_vec,
    input logic                      disp_valid,
    input logic                      disp_ready,
    input logic                      disp_tracked,
    input logic [$clog2(N_ENT)-1:0]  disp_entry,
    input logic                      rpt_valid,
    input logic                      rpt_hit,
    input logic [N_ENT-1:0]          cancel_vec,
    input logic                      rpl_valid,
    input logic [$clog2(N_ENT)-1:0]  rpl_entry
);
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cancel_vec == '0) && !rpl_valid && disp_ready);

    a_r2_alloc_into_free: assert property (@(posedge clk) disable iff (!rst_n)
        disp_tracked |-> !ent_vld[disp_entry]);

    a_r5_cancel_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (|cancel_vec) |-> ($past(rpt_valid && !rpt_hit) || $past(disp_valid && disp_ready)));

    a_r6_replay_entry_live: assert property (@(posedge clk) disable iff (!rst_n)
        rpl_valid |-> ent_vld[rpl_entry]);

    a_r7_single_pick: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pick_vec) && (rpl_valid == (|pick_vec)));

    a_r7_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        (rpl_valid && $past(rpl_valid)) |-> (rpl_entry != $past(rpl_entry)));

    a_r8_full_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (&ent_vld) |-> (!disp_ready && !disp_tracked));
endmodule

bind rt_replay_tracker rt_replay_tracker_chk #(.N_ENT(N_ENT), .N_LD(N_LD)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ent_vld      (ent_vld),
    .pick_vec     (pick_vec),
    .disp_valid   (disp_valid),
    .disp_ready   (disp_ready),
    .disp_tracked (disp_tracked),
    .disp_entry   (disp_entry),
    .rpt_valid    (rpt_valid),
    .rpt_hit      (rpt_hit),
    .cancel_vec   (cancel_vec),
    .rpl_valid    (rpl_valid),
    .rpl_entry    (rpl_entry)
);

// File: tb/test_rt_replay_tracker.sv
module test_rt_replay_tracker;
    localparam int N  = 16;
    localparam int L  = 4;
    localparam int UW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          disp_valid;
    logic [UW-1:0] disp_uop_id;
    logic [L-1:0]  disp_ld_mask;
    logic          disp_src0_vld;
    logic [3:0]    disp_src0_ent;
    logic          disp_src1_vld;
    logic [3:0]    disp_src1_ent;
    logic          disp_ready;
    logic          disp_tracked;
    logic [3:0]    disp_entry;
    logic          rpt_valid;
    logic [1:0]    rpt_tag;
    logic          rpt_hit;
    logic          fill_valid;
    logic [1:0]    fill_tag;
    logic [N-1:0]  cancel_vec;
    logic          rpl_valid;
    logic [3:0]    rpl_entry;
    logic [UW-1:0] rpl_uop_id;

    always #5 clk = ~clk;

    rt_replay_tracker i_rt_replay_tracker (
        .clk(clk), .rst_n(rst_n),
        .disp_valid(disp_valid), .disp_uop_id(disp_uop_id), .disp_ld_mask(disp_ld_mask),
        .disp_src0_vld(disp_src0_vld), .disp_src0_ent(disp_src0_ent),
        .disp_src1_vld(disp_src1_vld), .disp_src1_ent(disp_src1_ent),
        .disp_ready(disp_ready), .disp_tracked(disp_tracked), .disp_entry(disp_entry),
        .rpt_valid(rpt_valid), .rpt_tag(rpt_tag), .rpt_hit(rpt_hit),
        .fill_valid(fill_valid), .fill_tag(fill_tag),
        .cancel_vec(cancel_vec), .rpl_valid(rpl_valid), .rpl_entry(rpl_entry),
        .rpl_uop_id(rpl_uop_id)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // behavioural reference state
    bit mvld [N];
    int mmask [N];
    bit mrpl [N];
    int mseq [N];
    int muop [N];
    int mmissed;
    int mcancel;
    int seqc;
    // reference combinational results
    bit m_ready, m_track, m_rvalid;
    int m_entry, m_rentry, m_newmask;

    task automatic cmp(string req, int got, int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            mvld[i] = 0; mmask[i] = 0; mrpl[i] = 0; mseq[i] = 0; muop[i] = 0;
        end
        mmissed = 0; mcancel = 0; seqc = 0;
    endtask

    task automatic model_eval();
        int best;
        m_ready = 0;
        m_entry = 0;
        for (int i = N - 1; i >= 0; i--) if (!mvld[i]) begin m_ready = 1; m_entry = i; end
        m_newmask = int'(disp_ld_mask);
        if (disp_src0_vld && mvld[disp_src0_ent]) m_newmask |= mmask[disp_src0_ent];
        if (disp_src1_vld && mvld[disp_src1_ent]) m_newmask |= mmask[disp_src1_ent];
        m_track = disp_valid && m_ready && (m_newmask != 0);
        m_rvalid = 0; m_rentry = 0; best = 0;
        for (int i = 0; i < N; i++) begin
            if (mvld[i] && mrpl[i] && ((mmask[i] & mmissed) == 0)) begin
                if (!m_rvalid || mseq[i] < best) begin
                    m_rvalid = 1; m_rentry = i; best = mseq[i];
                end
            end
        end
    endtask

    task automatic model_update();
        int nc;
        nc = 0;
        if (m_rvalid) mrpl[m_rentry] = 0;
        if (m_track) begin
            mvld[m_entry] = 1; mmask[m_entry] = m_newmask; muop[m_entry] = int'(disp_uop_id);
            mseq[m_entry] = seqc; seqc++;
            mrpl[m_entry] = (m_newmask & mmissed) != 0;
            if (mrpl[m_entry]) nc |= (1 << m_entry);
        end
        if (rpt_valid) begin
            if (!rpt_hit) mmissed |= (1 << rpt_tag);
            for (int i = 0; i < N; i++) begin
                if (mvld[i] && mmask[i][rpt_tag]) begin
                    if (rpt_hit) mmask[i] &= ~(1 << rpt_tag);
                    else begin
                        if (!mrpl[i]) nc |= (1 << i);
                        mrpl[i] = 1;
                    end
                end
            end
        end
        if (fill_valid) begin
            mmissed &= ~(1 << fill_tag);
            for (int i = 0; i < N; i++) mmask[i] &= ~(1 << fill_tag);
        end
        for (int i = 0; i < N; i++) if (mvld[i] && mmask[i] == 0 && !mrpl[i]) mvld[i] = 0;
        mcancel = nc;
    endtask

    task automatic compare_all();
        cmp("R8 ready", int'(disp_ready), int'(m_ready));
        cmp("R2 tracked", int'(disp_tracked), int'(m_track));
        if (m_track) cmp("R2 entry", int'(disp_entry), m_entry);
        cmp("R5 cancel", int'(cancel_vec), mcancel);
        cmp("R7 replay valid", int'(rpl_valid), int'(m_rvalid));
        if (m_rvalid) begin
            cmp("R7 replay entry", int'(rpl_entry), m_rentry);
            cmp("R7 replay uop", int'(rpl_uop_id), muop[m_rentry]);
        end
    endtask

    task automatic clr();
        disp_valid = 0; disp_uop_id = '0; disp_ld_mask = '0;
        disp_src0_vld = 0; disp_src0_ent = '0; disp_src1_vld = 0; disp_src1_ent = '0;
        rpt_valid = 0; rpt_tag = '0; rpt_hit = 0; fill_valid = 0; fill_tag = '0;
    endtask

    task automatic step();
        #1;
        model_eval();
        compare_all();
        @(posedge clk);
        model_update();
        @(negedge clk);
        clr();
    endtask

    task automatic disp(int id, int ldm, bit s0v, int s0, bit s1v, int s1);
        disp_valid = 1; disp_uop_id = UW'(id); disp_ld_mask = L'(ldm);
        disp_src0_vld = s0v; disp_src0_ent = 4'(s0);
        disp_src1_vld = s1v; disp_src1_ent = 4'(s1);
    endtask

    task automatic rpt(int tag, bit hit);
        rpt_valid = 1; rpt_tag = 2'(tag); rpt_hit = hit;
    endtask

    task automatic fill(int tag);
        fill_valid = 1; fill_tag = 2'(tag);
    endtask

    // random stimulus tag bookkeeping: 0 free, 1 awaiting report, 2 missed awaiting fill
    int tst [L];
    int tcnt [L];

    initial begin
        clr();
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        cmp("R1 cancel", int'(cancel_vec), 0);
        cmp("R1 replay", int'(rpl_valid), 0);
        cmp("R1 ready", int'(disp_ready), 1);
        step();

        // R2: independent micro-op not tracked
        disp(8'h10, 0, 0, 0, 0, 0); #1; cmp("R2 untracked", int'(disp_tracked), 0); step();
        disp(8'h11, 1, 0, 0, 0, 0); #1; cmp("R2 first entry", int'(disp_entry), 0); step();
        // R3: inherits through producer only
        disp(8'h12, 0, 1, 0, 0, 0); #1; cmp("R3 inherit tracked", int'(disp_tracked), 1);
        cmp("R3 inherit entry", int'(disp_entry), 1); step();
        disp(8'h13, 2, 0, 0, 0, 0); step();
        disp(8'h14, 0, 1, 1, 1, 2); step();
        rpt(1, 1); step();                                   // hit tag1
        disp(8'h15, 4, 0, 0, 0, 0); rpt(0, 0);
        #1; cmp("R4 freed entry reused", int'(disp_entry), 2); step();
        #1; cmp("R5 cancel chain", int'(cancel_vec), 32'h000B);
        disp(8'h16, 0, 1, 3, 0, 0); step();
        #1; cmp("R9 born cancelled", int'(cancel_vec), 32'h0010);
        cmp("R6 hold before fill", int'(rpl_valid), 0); step();
        #1; cmp("R6 hold before fill", int'(rpl_valid), 0); step();
        fill(0); #1; cmp("R6 hold in fill cycle", int'(rpl_valid), 0); step();
        #1; cmp("R7 oldest first", int'(rpl_entry), 0); cmp("R7 uop", int'(rpl_uop_id), 8'h11); step();
        #1; cmp("R7 second", int'(rpl_entry), 1); step();
        #1; cmp("R7 third", int'(rpl_entry), 3); step();
        #1; cmp("R7 fourth", int'(rpl_entry), 4); step();
        disp(8'h17, 5, 0, 0, 0, 0);
        #1; cmp("R7 drained", int'(rpl_valid), 0); cmp("R4 entry0 free", int'(disp_entry), 0); step();
        rpt(0, 0); step();
        #1; cmp("R5 single cancel", int'(cancel_vec), 1); step();
        fill(0); step();
        #1; cmp("R10 replay", int'(rpl_uop_id), 8'h17); step();
        disp(8'h18, 4, 0, 0, 0, 0); #1; cmp("R10 still held", int'(disp_entry), 1); step();
        rpt(2, 1); step();
        disp(8'h19, 8, 0, 0, 0, 0); #1; cmp("R10 freed after last tag", int'(disp_entry), 0); step();
        for (int k = 0; k < N - 1; k++) begin
            disp(8'h20 + k, 8, 0, 0, 0, 0); step();
        end
        disp(8'h40, 8, 0, 0, 0, 0);
        #1; cmp("R8 full", int'(disp_ready), 0); cmp("R8 no alloc", int'(disp_tracked), 0); step();
        rpt(3, 1); step();
        #1; cmp("R4 all retired", int'(disp_ready), 1); step();

        // random phase
        for (int t = 0; t < L; t++) begin tst[t] = 0; tcnt[t] = 0; end
        for (int c = 0; c < 4000; c++) begin
            int outst, resolving, freeset, t;
            bit did_rpt, did_fill;
            freeset = 0;
            for (int k = 0; k < L; k++) if (tst[k] == 0) freeset |= (1 << k);
            for (int k = 0; k < L; k++) if (tst[k] != 0 && tcnt[k] > 0) tcnt[k]--;
            did_rpt = 0; did_fill = 0; resolving = 0;
            for (int k = 0; k < L; k++) begin
                if (!did_rpt && tst[k] == 1 && tcnt[k] == 0) begin
                    did_rpt = 1; resolving |= (1 << k);
                    if (($urandom % 10) < 6) begin rpt(k, 1); tst[k] = 0; end
                    else begin rpt(k, 0); tst[k] = 2; tcnt[k] = 3 + int'($urandom % 6); end
                end else if (!did_fill && tst[k] == 2 && tcnt[k] == 0) begin
                    did_fill = 1; resolving |= (1 << k); fill(k); tst[k] = 0;
                end
            end
            if (freeset != 0 && ($urandom % 3) == 0) begin
                t = int'($urandom % L);
                if (freeset[t]) begin tst[t] = 1; tcnt[t] = 2; end
            end
            outst = 0;
            for (int k = 0; k < L; k++) if (tst[k] != 0) outst |= (1 << k);
            outst &= ~resolving;
            if (($urandom % 4) != 0) begin
                disp(int'($urandom % 256), int'($urandom) & outst,
                     ($urandom % 2) == 1, int'($urandom % N),
                     ($urandom % 3) == 1, int'($urandom % N));
            end
            step();
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule